// File: doc/BRIEF.md
# Multichannel Stream Serializer with Shared Storage

This block merges several byte-wide producer streams onto one outgoing byte stream. Each producer sees a private channel with its own full and empty flags. No channel owns any storage, though. A channel is only a pair of counters. They track how many of its bytes are inside the block, and that count sets the flags the producer sees as backpressure. Every byte, from every channel, sits in one common storage FIFO.

A producer offers data in chunks. It raises its valid line with the chunk's byte count on a length bus and then presents the payload bytes one at a time. The block places a two-byte header in the common FIFO ahead of the payload, and the chunk is written there whole. The header byte that comes first holds the channel number, and the byte after it holds the payload length. The single valid/ready output carries headers and payloads interleaved, ready for a downstream link to frame and send. A receiver can decode the headers to route each payload back to its channel.

Top module: `mcs_serializer`

## Requirements
- R1: After reset, out_valid is low, every ch_empty bit is high, and every ch_full and ch_ready bit is low.
- R2: Each chunk appears on the output as header byte 0 (the channel number, zero-extended to 8 bits), then header byte 1 (the payload byte count), then the payload bytes in the order they were accepted.
- R3: A channel's full flag is high when the number of its bytes accepted, minus the number of its payload bytes that have left on the output, equals CH_DEPTH. While the flag is high, that channel's ch_ready stays low.
- R4: A channel's empty flag is high exactly when none of its payload bytes is held in the block.
- R5: When several channels raise valid in the same idle cycle, the lowest-numbered channel's chunk is taken first.
- R6: Once a chunk has started, no byte of any other channel enters between its header and its last payload byte. At most one ch_ready bit is high at a time.
- R7: While out_valid is high and out_ready is low, out_data and out_valid hold their values. No payload byte counts as read during the stall, so a full channel stays full.
- R8: No further arbitration is applied. A chunk already started is finished before any channel that raises valid afterwards, even a lower-numbered one.
- R9: Chunk lengths from 1 up to 255 bytes are carried, with the header's length byte equal to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | N_CH | Per-channel: chunk/byte offered |
| ch_len | input | 8*N_CH | Per-channel chunk byte count (1..255), held with valid |
| ch_data | input | 8*N_CH | Per-channel payload byte |
| ch_ready | output | N_CH | Per-channel: byte accepted this cycle when valid |
| ch_full | output | N_CH | Per-channel virtual FIFO full |
| ch_empty | output | N_CH | Per-channel virtual FIFO empty |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte (header or payload) |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
If a channel's counters drift, its full flag rises or falls at the wrong byte count. A full channel that is stalled then shows a ch_ready that is wrong, within one cycle of the count that should have set the flag. A sequencer that loses its owner or its remaining count shows up at once in the captured output stream. The symptom is a header with the wrong channel or length, or foreign bytes inside a chunk. The bench therefore compares each chunk byte for byte. It also checks the flags at known points while the output is stalled.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
   localparam int ID_W   = 3;
   localparam int MAX_CH = 1 << ID_W;

   typedef struct packed {
      logic            hdr;
      logic [ID_W-1:0] ch;
      logic [7:0]      data;
   } slot_t;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_HID  = 2'd1,
      S_HLEN = 2'd2,
      S_PAY  = 2'd3
   } seq_e;
endpackage

// File: rtl/mcs_vchan.sv
module mcs_vchan #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_inc,
   input  logic rd_inc,
   output logic full,
   output logic empty
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("mcs_vchan: DEPTH must be at least 1");
   end

   logic [CW-1:0] wr_cnt, rd_cnt, occ;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_cnt <= '0;
         rd_cnt <= '0;
      end else begin
         if (wr_inc) wr_cnt <= wr_cnt + 1'b1;
         if (rd_inc) rd_cnt <= rd_cnt + 1'b1;
      end
   end

   assign occ   = wr_cnt - rd_cnt;
   assign full  = (occ == CW'(DEPTH));
   assign empty = (occ == '0);

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !wr_inc);
   // R3
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH));
   // R4
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !rd_inc);
endmodule

// File: rtl/mcs_sfifo.sv
module mcs_sfifo
   import mcs_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  push,
   input  slot_t push_slot,
   input  logic  pop,
   output slot_t head,
   output logic  empty,
   output logic  full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("mcs_sfifo: DEPTH must be a power of two, at least 2");
   end

   slot_t         mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) begin
            mem[wp] <= push_slot;
            wp      <= wp + 1'b1;
         end
         if (pop) rp <= rp + 1'b1;
         cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      end
   end

   assign head  = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == (AW+1)'(DEPTH));

   // R6
   shared_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   // R7
   shared_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);
endmodule

// File: rtl/mcs_seq.sv
module mcs_seq
   import mcs_pkg::*;
#(
   parameter int N_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   ch_valid,
   input  logic [8*N_CH-1:0] ch_len,
   input  logic [8*N_CH-1:0] ch_data,
   input  logic [N_CH-1:0]   vfull,
   input  logic              sfull,
   output logic [N_CH-1:0]   ch_ready,
   output logic              push,
   output slot_t             push_slot
);
   seq_e            st;
   logic [ID_W-1:0] own;
   logic [7:0]      left, len_r;
   logic [ID_W-1:0] pick;
   logic [7:0]      pick_len, own_data;
   logic            acc;

   // lowest-numbered requester wins
   always_comb begin
      pick     = '0;
      pick_len = '0;
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (ch_valid[i]) begin
            pick     = ID_W'(i);
            pick_len = ch_len[8*i +: 8];
         end
      end
   end

   always_comb begin
      own_data = '0;
      ch_ready = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (own == ID_W'(i)) begin
            own_data    = ch_data[8*i +: 8];
            ch_ready[i] = (st == S_PAY) && !vfull[i] && !sfull;
         end
      end
      acc = |(ch_ready & ch_valid);
   end

   always_comb begin
      push      = 1'b0;
      push_slot = '0;
      unique case (st)
         S_HID: begin
            push      = !sfull;
            push_slot = '{hdr: 1'b1, ch: own, data: 8'(own)};
         end
         S_HLEN: begin
            push      = !sfull;
            push_slot = '{hdr: 1'b1, ch: own, data: len_r};
         end
         S_PAY: begin
            push      = acc;
            push_slot = '{hdr: 1'b0, ch: own, data: own_data};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         own   <= '0;
         left  <= '0;
         len_r <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (|ch_valid) begin
               own   <= pick;
               len_r <= pick_len;
               left  <= pick_len;
               st    <= S_HID;
            end
            S_HID:  if (!sfull) st <= S_HLEN;
            S_HLEN: if (!sfull) st <= S_PAY;
            S_PAY:  if (acc) begin
               left <= left - 1'b1;
               if (left == 8'd1) st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R6
   ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_ready));
   // R6
   owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_PAY && !(acc && left == 8'd1)) |=> (st == S_PAY && $stable(own)));
   // R9
   len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_HLEN) |-> (len_r != 8'd0));
endmodule

// File: rtl/mcs_serializer.sv
module mcs_serializer
   import mcs_pkg::*;
#(
   parameter int N_CH     = 3,
   parameter int CH_DEPTH = 4,
   parameter int SH_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   ch_valid,
   input  logic [8*N_CH-1:0] ch_len,
   input  logic [8*N_CH-1:0] ch_data,
   output logic [N_CH-1:0]   ch_ready,
   output logic [N_CH-1:0]   ch_full,
   output logic [N_CH-1:0]   ch_empty,
   output logic              out_valid,
   output logic [7:0]        out_data,
   input  logic              out_ready
);
   if (N_CH < 1 || N_CH > MAX_CH) begin : g_bad_nch
      $error("mcs_serializer: N_CH out of range");
   end

   logic  push, pop, s_empty, s_full;
   slot_t push_slot, head;

   mcs_seq #(.N_CH(N_CH)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ch_valid (ch_valid),
      .ch_len   (ch_len),
      .ch_data  (ch_data),
      .vfull    (ch_full),
      .sfull    (s_full),
      .ch_ready (ch_ready),
      .push     (push),
      .push_slot(push_slot)
   );

   mcs_sfifo #(.DEPTH(SH_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_slot(push_slot),
      .pop      (pop),
      .head     (head),
      .empty    (s_empty),
      .full     (s_full)
   );

   assign out_valid = !s_empty;
   assign out_data  = head.data;
   assign pop       = out_valid && out_ready;

   for (genvar i = 0; i < N_CH; i++) begin : g_vch
      mcs_vchan #(.DEPTH(CH_DEPTH)) u_vch (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_inc(ch_valid[i] && ch_ready[i]),
         .rd_inc(pop && !head.hdr && (head.ch == ID_W'(i))),
         .full  (ch_full[i]),
         .empty (ch_empty[i])
      );
   end

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   // R7
   stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_ready && ch_full != '0) |=> ((ch_full & $past(ch_full)) == $past(ch_full)));
endmodule

// File: tb/sim_mcs_serializer.sv
module sim_mcs_serializer;
   localparam int CLK_P = 10;
   localparam int N     = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]   vld = '0;
   logic [7:0]     dat [N];
   logic [7:0]     ln  [N];
   logic [8*N-1:0] ch_len, ch_data;
   logic [N-1:0]   ch_ready, ch_full, ch_empty;
   logic           out_valid, out_ready = 1'b0;
   logic [7:0]     out_data;

   int checks = 0, fails = 0;
   logic [7:0] q [$];

   always #(CLK_P/2) clk = ~clk;

   always_comb
      for (int i = 0; i < N; i++) begin
         ch_len[8*i +: 8]  = ln[i];
         ch_data[8*i +: 8] = dat[i];
      end

   mcs_serializer #(.N_CH(N), .CH_DEPTH(4), .SH_DEPTH(8)) u0 (
      .clk(clk), .rst_n(rst_n), .ch_valid(vld), .ch_len(ch_len), .ch_data(ch_data),
      .ch_ready(ch_ready), .ch_full(ch_full), .ch_empty(ch_empty),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
   );

   always @(negedge clk)
      if (rst_n && out_valid && out_ready) q.push_back(out_data);

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input int ch, input int n, input logic [7:0] base);
      ln[ch]  = 8'(n);
      vld[ch] = 1'b1;
      for (int k = 0; k < n; k++) begin
         dat[ch] = base + 8'(k);
         do @(negedge clk); while (!ch_ready[ch]);
         @(posedge clk); #1;
      end
      vld[ch] = 1'b0;
   endtask

   task automatic drain();
      int quiet = 0;
      while (quiet < 4) begin
         @(negedge clk);
         if (!out_valid) quiet++; else quiet = 0;
      end
      @(posedge clk); #1;
   endtask

   task automatic cmp_stream(input string tag, input logic [7:0] exp [$]);
      check(q.size() == exp.size(), {tag, " length"}, q.size(), exp.size());
      for (int k = 0; k < exp.size() && k < q.size(); k++)
         if (q[k] !== exp[k]) begin
            check(1'b0, $sformatf("%s byte %0d", tag, k), q[k], exp[k]);
            return;
         end
      check(1'b1, tag, 0, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      check(ch_empty == '1, "R1 ch_empty", ch_empty, 3'b111);
      check(ch_full == '0, "R1 ch_full", ch_full, 0);
      check(ch_ready == '0, "R1 ch_ready", ch_ready, 0);
   endtask

   task automatic t_single();
      q.delete();
      out_ready = 1'b1;
      send(1, 3, 8'hA0);
      drain();
      cmp_stream("R2 single chunk", '{8'h01, 8'h03, 8'hA0, 8'hA1, 8'hA2});
   endtask

   task automatic t_same_cycle();
      q.delete();
      fork
         send(2, 2, 8'h90);
         send(0, 2, 8'hB0);
      join
      drain();
      cmp_stream("R5 R6 lowest first, no interleave",
         '{8'h00, 8'h02, 8'hB0, 8'hB1, 8'h02, 8'h02, 8'h90, 8'h91});
   endtask

   task automatic t_order();
      q.delete();
      fork
         send(2, 3, 8'h70);
         begin repeat (2) @(posedge clk); #1; send(0, 1, 8'h80); end
      join
      drain();
      cmp_stream("R8 started chunk finishes first",
         '{8'h02, 8'h03, 8'h70, 8'h71, 8'h72, 8'h00, 8'h01, 8'h80});
   endtask

   task automatic t_stall();
      logic [7:0] held;
      q.delete();
      out_ready = 1'b0;
      fork send(1, 5, 8'h40); join_none
      repeat (12) @(posedge clk);
      @(negedge clk);
      check(ch_full[1] == 1'b1, "R3 full at depth", ch_full[1], 1);
      check(ch_ready[1] == 1'b0, "R3 ready low when full", ch_ready[1], 0);
      check(ch_empty[1] == 1'b0, "R4 not empty", ch_empty[1], 0);
      check(out_valid && out_data == 8'h01, "R7 head byte", out_data, 8'h01);
      held = out_data;
      repeat (3) @(negedge clk);
      check(out_data == held && out_valid, "R7 held during stall", out_data, held);
      check(ch_full[1] == 1'b1, "R7 full stays full", ch_full[1], 1);
      @(posedge clk); #1;
      out_ready = 1'b1;
      wait fork;
      drain();
      check(ch_empty[1] == 1'b1, "R4 empty after drain", ch_empty[1], 1);
      cmp_stream("R2 R3 stalled chunk",
         '{8'h01, 8'h05, 8'h40, 8'h41, 8'h42, 8'h43, 8'h44});
   endtask

   task automatic t_long();
      logic [7:0] e [$];
      q.delete();
      e.push_back(8'h02);
      e.push_back(8'hFF);
      for (int k = 0; k < 255; k++) e.push_back(8'(k + 5));
      send(2, 255, 8'h05);
      drain();
      cmp_stream("R9 255-byte chunk", e);
   endtask

   task automatic t_short();
      q.delete();
      send(0, 1, 8'h3C);
      drain();
      cmp_stream("R9 one-byte chunk", '{8'h00, 8'h01, 8'h3C});
      check(ch_empty == '1, "R4 all empty at end", ch_empty, 3'b111);
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin dat[i] = '0; ln[i] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_single();
      t_same_cycle();
      t_order();
      t_stall();
      t_long();
      t_short();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule